// File: doc/BRIEF.md
# Serial Memory Command Front-End

This block is the slave side of a four-wire serial link that talks to a small byte-wide memory. It runs on the system clock and samples the select, serial clock, data-in and pause inputs every cycle. It finds the serial clock edges itself and works with the clock idling either low or high. It shifts in an instruction byte and decodes it. It then collects an address byte and either sends bytes out, most significant bit first, or passes incoming bytes to the memory side one at a time.

The memory side is simple. The block presents an address and takes read data back combinationally. For each byte written it gives a single-cycle write strobe. When select rises at a legal point it gives a commit pulse with a command kind code. The storage array, the status register and the write timer sit in other blocks. They keep strobed write bytes pending and act on them only when the commit pulse arrives. The block also handles the pause (hold) input, the guard that blocks commands until select has been seen high after reset, and the rule that a command counts only when select rises inside the legal window.

Top module: `spi_mem_front`

## Requirements
- R1: After reset `spi_miso_oe`, `mem_wr` and `cmd_commit` are 0.
- R2: If select is already low when reset ends, nothing is decoded until select has gone high and then low again. A full instruction clocked during that time gives no commit.
- R3: Opcode 0x06 commits with `cmd_kind`=0 and opcode 0x04 commits with `cmd_kind`=1. In both cases the commit is a one-cycle `cmd_commit` pulse after select rises. It is given only when exactly eight serial clock rising edges were seen since select fell.
- R4: A committing command is dropped, with no `cmd_commit`, if select rises before its last byte is complete. It is also dropped if another rising serial clock edge comes after that byte and before select rises.
- R5: Read uses opcode 0x03 with opcode bit 3 as address bit 8. It is followed by one address byte. Output bits change after falling serial clock edges and are sampled before the rising edges. Data is sent MSB first from successive addresses, and the address wraps from 0x1FF to 0x000.
- R6: Opcode 0x05 repeatedly outputs the `status_in` byte, MSB first, for as long as select stays low.
- R7: Write uses opcode 0x02 with opcode bit 3 as address bit 8. It is followed by one address byte. Each complete data byte gives one `mem_wr` pulse with `mem_addr` and `mem_wdata`. The low four address bits step and wrap inside the 16-byte page. A commit with `cmd_kind`=3 follows only if select rises right after a complete data byte.
- R8: Opcode 0x01 followed by one data byte commits with `cmd_kind`=2 and that byte on `mem_wdata`. It gives no `mem_wr`, and any extra bit drops the commit.
- R9: `spi_miso_oe` is 0 whenever select is high, and is 1 while read or status data is being sent.
- R10: A pause starts only when `spi_hold_n` is low while the serial clock is low. During a pause `spi_miso_oe` is 0 and serial clock and data are ignored. Releasing the pause with the clock low resumes the transfer unchanged.
- R11: An unknown opcode gives no commit, no write and no output until select rises. The next command works normally.
- R12: Every command behaves the same with the serial clock idling high as with it idling low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_miso | output | 1 | Serial data out value |
| spi_miso_oe | output | 1 | Output enable for the serial data out driver |
| mem_addr | output | AW | Memory byte address |
| mem_rdata | input | 8 | Read data at `mem_addr` |
| status_in | input | 8 | Status byte to send for the status command |
| mem_wr | output | 1 | One-cycle write-byte strobe |
| mem_wdata | output | 8 | Write byte, or status byte on commit |
| cmd_commit | output | 1 | One-cycle commit pulse |
| cmd_kind | output | 2 | Committed command: 0 enable, 1 disable, 2 status write, 3 write |

## Verification
The assertions check the following on every cycle. The output enable is off while deselected and during an established pause. Commit pulses only follow a select rise, and write strobes only follow a selected cycle. Write strobes are single pulses that never coincide with a commit. The bench scenarios are needed for the rest: the commit window boundaries, the power-up guard, read data order and address wrap, page wrap on writes, and transfers that resume correctly after a pause. These depend on whole serial sequences and on expected memory contents.

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int AW   = 9,
  parameter int PAGE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  input  logic          spi_hold_n,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  input  logic [7:0]    status_in,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  output logic          cmd_commit,
  output logic [1:0]    cmd_kind
);
  localparam int PW     = $clog2(PAGE);
  localparam bit HAS_A8 = (AW > 8);

  typedef enum logic [2:0] {S_OPC, S_ADR, S_WIN, S_SR, S_RD, S_IGN} st_t;

  st_t           st;
  logic          sck_q, cs_q, sel, held, ok, adv, oe_r, q_r, rd, a_hi;
  logic [2:0]    bcnt;
  logic [6:0]    sh;
  logic [AW-1:0] addr;
  logic [1:0]    kind;
  logic [7:0]    obyte;

  wire       cs_fall = ~spi_cs_n & cs_q;
  wire       cs_rise = spi_cs_n & ~cs_q & sel;
  wire       live    = sel & ~spi_cs_n & ~held;
  wire       sck_r   = live & spi_sck & ~sck_q;
  wire       sck_f   = live & ~spi_sck & sck_q;
  wire [7:0] byte_in = {sh, spi_mosi};
  wire       bit7    = (bcnt == 3'd7);
  wire       hi_ok   = (byte_in[7:4] == 4'h0) && (HAS_A8 || !byte_in[3]);
  wire       is_rd   = hi_ok && (byte_in[2:0] == 3'b011);
  wire       is_wr   = hi_ok && (byte_in[2:0] == 3'b010);
  wire [8:0] a_full  = {a_hi & HAS_A8, byte_in};
  wire [7:0] src     = (st == S_SR) ? status_in : mem_rdata;

  assign mem_addr    = addr;
  assign spi_miso_oe = oe_r & sel & ~held & ~spi_cs_n;
  assign spi_miso    = spi_miso_oe & q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b0; sel <= 1'b0; held <= 1'b0;
      st <= S_IGN; bcnt <= '0; sh <= '0; addr <= '0; a_hi <= 1'b0;
      kind <= '0; ok <= 1'b0; adv <= 1'b0; rd <= 1'b0;
      oe_r <= 1'b0; q_r <= 1'b0; obyte <= '0;
      mem_wr <= 1'b0; mem_wdata <= '0; cmd_commit <= 1'b0; cmd_kind <= '0;
    end else begin
      sck_q      <= spi_sck;
      cs_q       <= spi_cs_n;
      mem_wr     <= 1'b0;
      cmd_commit <= 1'b0;
      if (!spi_sck) held <= ~spi_hold_n;
      if (cs_fall) begin
        sel <= 1'b1; st <= S_OPC; bcnt <= '0;
        ok <= 1'b0; adv <= 1'b0; oe_r <= 1'b0;
      end else if (cs_rise) begin
        sel <= 1'b0; oe_r <= 1'b0; st <= S_IGN;
        if (ok) begin
          cmd_commit <= 1'b1;
          cmd_kind   <= kind;
        end
      end else if (sck_r) begin
        bcnt <= bcnt + 3'd1;
        sh   <= byte_in[6:0];
        ok   <= 1'b0;
        case (st)
          S_OPC: if (bit7) begin
            a_hi <= byte_in[3];
            rd   <= is_rd;
            if (byte_in == 8'h06)      begin kind <= 2'd0; ok <= 1'b1; st <= S_IGN; end
            else if (byte_in == 8'h04) begin kind <= 2'd1; ok <= 1'b1; st <= S_IGN; end
            else if (byte_in == 8'h05) st <= S_SR;
            else if (byte_in == 8'h01) begin kind <= 2'd2; st <= S_WIN; end
            else if (is_rd)            st <= S_ADR;
            else if (is_wr)            begin kind <= 2'd3; st <= S_ADR; end
            else                       st <= S_IGN;
          end
          S_ADR: if (bit7) begin
            addr <= a_full[AW-1:0];
            st   <= rd ? S_RD : S_WIN;
          end
          S_WIN: begin
            if (adv && bcnt == 3'd0) begin
              addr <= {addr[AW-1:PW], addr[PW-1:0] + PW'(1)};
              adv  <= 1'b0;
            end
            if (bit7) begin
              mem_wdata <= byte_in;
              ok        <= 1'b1;
              if (kind == 2'd2) st <= S_IGN;
              else begin
                mem_wr <= 1'b1;
                adv    <= 1'b1;
              end
            end
          end
          S_RD: if (bit7) addr <= addr + AW'(1);
          default: ;
        endcase
      end else if (sck_f && (st == S_RD || st == S_SR)) begin
        oe_r <= 1'b1;
        if (bcnt == 3'd0) begin
          obyte <= src;
          q_r   <= src[7];
        end else begin
          q_r <= obyte[3'd7 - bcnt];
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_hold_n,
  input logic spi_miso_oe,
  input logic mem_wr,
  input logic cmd_commit
);
  assert_oe_off_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_miso_oe);

  assert_commit_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_commit |-> ($past(spi_cs_n) && !$past(spi_cs_n, 2)));

  assert_wr_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  assert_wr_while_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !$past(spi_cs_n));

  assert_wr_commit_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && cmd_commit));

  assert_pause_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_hold_n && $past(!spi_hold_n && !spi_sck)) |-> !spi_miso_oe);
endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .spi_hold_n(spi_hold_n), .spi_miso_oe(spi_miso_oe),
  .mem_wr(mem_wr), .cmd_commit(cmd_commit)
);

// File: tb/spi_mem_front_tb.sv
module spi_mem_front_tb;
  localparam int H = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, cs_n, sck, mosi, hold_n, miso, miso_oe, mem_wr, cmd_commit;
  logic [8:0] mem_addr;
  logic [7:0] mem_rdata, mem_wdata;
  logic [7:0] status_in = 8'hA7;
  logic [1:0] cmd_kind;

  int n_chk = 0, n_bad = 0, wn = 0, cn = 0;
  logic [8:0] wa [0:255];
  logic [7:0] wd [0:255];
  logic [1:0] ck;
  logic [7:0] cw;
  bit mode3 = 0, done = 0;

  function automatic logic [7:0] mem_f(input logic [8:0] a);
    return (a[7:0] * 8'd29) ^ {7'b0, a[8]} ^ 8'h5C;
  endfunction

  assign mem_rdata = mem_f(mem_addr);

  spi_mem_front u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .status_in(status_in),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .cmd_commit(cmd_commit), .cmd_kind(cmd_kind)
  );

  always @(negedge clk) begin
    if (mem_wr) begin wa[wn[7:0]] <= mem_addr; wd[wn[7:0]] <= mem_wdata; wn <= wn + 1; end
    if (cmd_commit) begin ck <= cmd_kind; cw <= mem_wdata; cn <= cn + 1; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    sck = mode3; tick(H); cs_n = 0; tick(H);
  endtask

  task automatic bitx(input logic b, output logic r);
    sck = 0; mosi = b; tick(H); r = miso; sck = 1; tick(H);
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bitx(b[i], r[i]);
  endtask

  task automatic desel();
    if (!mode3) sck = 0;
    tick(H); cs_n = 1; tick(H); sck = mode3; tick(H);
  endtask

  task automatic t_write(input logic [8:0] a, input int len, input string tag);
    int b0 = wn, c0 = cn;
    logic [7:0] r;
    logic [7:0] dat [0:31];
    sel();
    xbyte({4'b0, a[8], 3'b010}, r);
    xbyte(a[7:0], r);
    for (int i = 0; i < len; i++) begin
      dat[i] = 8'($urandom);
      xbyte(dat[i], r);
    end
    desel();
    check(wn - b0 == len, {"R7 write count ", tag}, wn - b0, len);
    for (int i = 0; i < len && i < 32; i++) begin
      logic [8:0] ea;
      ea = {a[8:4], a[3:0] + 4'(i)};
      check(wa[8'(b0 + i)] == ea, {"R7 write addr ", tag}, wa[8'(b0 + i)], ea);
      check(wd[8'(b0 + i)] == dat[i], {"R7 write data ", tag}, wd[8'(b0 + i)], dat[i]);
    end
    check(cn == c0 + 1 && ck == 2'd3, {"R7 write commit ", tag}, cn - c0, 1);
  endtask

  task automatic t_read(input logic [8:0] a, input int len, input string tag);
    int c0 = cn;
    logic [7:0] r;
    sel();
    xbyte({4'b0, a[8], 3'b011}, r);
    xbyte(a[7:0], r);
    for (int i = 0; i < len; i++) begin
      logic [8:0] ea;
      ea = a + 9'(i);
      xbyte(8'h00, r);
      check(r == mem_f(ea), {"R5 read data ", tag}, r, mem_f(ea));
    end
    check(miso_oe == 1'b1, {"R9 oe on while reading ", tag}, miso_oe, 1);
    desel();
    check(miso_oe == 1'b0, {"R9 oe off after deselect ", tag}, miso_oe, 0);
    check(cn == c0, {"R5 read gives no commit ", tag}, cn - c0, 0);
  endtask

  task automatic t_single(input logic [7:0] op, input int nbits, input bit exp_c,
                          input logic [1:0] kind, input string tag);
    int c0 = cn;
    logic r;
    sel();
    for (int i = 0; i < nbits; i++) bitx(op[7 - (i % 8)], r);
    desel();
    check(cn == c0 + (exp_c ? 1 : 0), {tag, " commit count"}, cn - c0, exp_c ? 1 : 0);
    if (exp_c) check(ck == kind, {tag, " kind"}, ck, kind);
  endtask

  initial begin
    logic [7:0] r;
    logic b;
    int c0, w0;
    void'($urandom(32'd2024));
    rst_n = 0; cs_n = 0; sck = 0; mosi = 0; hold_n = 1;
    tick(4);
    rst_n = 1;
    tick(2);
    check(!miso_oe && !mem_wr && !cmd_commit, "R1 reset outputs", {miso_oe, mem_wr, cmd_commit}, 0);

    xbyte(8'h06, r);
    sck = 0; tick(H); cs_n = 1; tick(H);
    check(cn == 0, "R2 no commit before first select fall", cn, 0);

    mode3 = 0; t_single(8'h06, 8, 1, 2'd0, "R3 enable mode0");
    mode3 = 1; t_single(8'h04, 8, 1, 2'd1, "R3 R12 disable mode3");
    mode3 = 0; t_single(8'h06, 9, 0, 2'd0, "R4 extra bit");
    mode3 = 1; t_single(8'h06, 7, 0, 2'd0, "R4 short command");

    mode3 = 0; t_read(9'h1FE, 4, "wrap mode0");
    mode3 = 1; t_read(9'h07F, 3, "R12 mode3");

    mode3 = 1; c0 = cn;
    sel(); xbyte(8'h05, r);
    for (int i = 0; i < 2; i++) begin
      xbyte(8'h00, r);
      check(r == status_in, "R6 status byte", r, status_in);
    end
    desel();
    check(cn == c0, "R6 no commit", cn - c0, 0);

    mode3 = 0; t_write(9'h1FC, 6, "page wrap");
    mode3 = 1; t_write(9'h035, 2, "R12 mode3");

    mode3 = 0; c0 = cn; w0 = wn;
    sel(); xbyte(8'h02, r); xbyte(8'h40, r); xbyte(8'h99, r);
    for (int i = 0; i < 3; i++) bitx(1'b1, b);
    desel();
    check(wn - w0 == 1, "R7 one byte strobed", wn - w0, 1);
    check(cn == c0, "R4 mid-byte rise drops write", cn - c0, 0);

    c0 = cn; w0 = wn;
    sel(); xbyte(8'h01, r); xbyte(8'h8C, r); desel();
    check(cn == c0 + 1 && ck == 2'd2 && cw == 8'h8C, "R8 status write commit", cw, 8'h8C);
    check(wn == w0, "R8 no write strobe", wn - w0, 0);
    c0 = cn;
    sel(); xbyte(8'h01, r); xbyte(8'h8C, r); bitx(1'b0, b); desel();
    check(cn == c0, "R8 extra bit drops", cn - c0, 0);

    c0 = cn; w0 = wn;
    sel(); xbyte(8'hFF, r); xbyte(8'h10, r);
    check(miso_oe == 1'b0, "R11 no output on unknown", miso_oe, 0);
    xbyte(8'h55, r); desel();
    check(cn == c0 && wn == w0, "R11 unknown ignored", cn - c0 + wn - w0, 0);
    t_single(8'h06, 8, 1, 2'd0, "R11 next command works");

    mode3 = 0;
    sel(); xbyte(8'h03, r); xbyte(8'h10, r);
    for (int i = 7; i >= 4; i--) bitx(1'b0, r[i]);
    sck = 0; tick(H);
    hold_n = 0; tick(2);
    check(miso_oe == 1'b0, "R10 oe off in pause", miso_oe, 0);
    for (int k = 0; k < 3; k++) begin sck = 1; mosi = 1; tick(2); sck = 0; tick(2); end
    hold_n = 1; tick(2);
    check(miso_oe == 1'b1, "R10 oe back after release", miso_oe, 1);
    for (int i = 3; i >= 0; i--) bitx(1'b0, r[i]);
    check(r == mem_f(9'h010), "R10 byte intact across pause", r, mem_f(9'h010));
    bitx(1'b0, r[7]);
    hold_n = 0; tick(2);
    check(miso_oe == 1'b1, "R10 no pause while clock high", miso_oe, 1);
    hold_n = 1;
    for (int i = 6; i >= 0; i--) bitx(1'b0, r[i]);
    check(r == mem_f(9'h011), "R10 next byte after pause", r, mem_f(9'h011));
    desel();

    for (int it = 0; it < 40; it++) begin
      logic [8:0] a;
      mode3 = 1'($urandom);
      a = 9'($urandom);
      if ($urandom % 2) t_write(a, 1 + int'($urandom % 20), "random");
      else t_read(a, 1 + int'($urandom % 3), "random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule